// File: doc/BRIEF.md
# Microprogram Sequencer

This block is the control sequencer of a small horizontally microcoded processor. It holds an 8-bit microprogram counter and a 32-bit microinstruction register, and reads a 256-word constant microstore. Each microcycle has three subcycles, T1, T2 and T3, one clock each. At T1 the addressed word is fetched into the microinstruction register. At T2 the counter steps forward. At T3 the counter may instead take the word's target field, if the condition selected by the word holds on the current ALU flags.

The held word drives the datapath directly. Its three 5-bit register-select fields are each expanded into a 32-line one-hot enable vector for the C (write), A and B buses. Its ALU function, address-register load, memory read/write and branch fields appear as plain outputs. A word counts as executing from the moment it is held, so its effects belong to T2 and T3 of the same microcycle. The sequencer runs freely after reset and has no stream traffic, so it has no valid/ready handshake. The register bank, the ALU and main memory sit outside the block.

Top module: `useq_sequencer`

## Requirements
- R1: While synchronous reset is high, each clock edge clears the microprogram counter to 0 and the microinstruction register to 0, and returns the phase to T1. This holds whichever subcycle was in progress.
- R2: `phase_o` is one-hot, with bit 0 = T1, bit 1 = T2 and bit 2 = T3. It advances T1, T2, T3, T1 on successive clock edges.
- R3: On the clock edge taken in T1, the microinstruction register loads the microstore word addressed by the counter. It holds that word through the T2 and T3 edges.
- R4: On the clock edge taken in T2, the counter increments by one modulo 256, so 0xFF wraps to 0x00.
- R5: On the clock edge taken in T3, the counter loads the held word's target field when `br_take_o` is 1. Otherwise it keeps its value.
- R6: Word layout, most significant bit first: C [31:27], A [26:22], B [21:17], ALU [16:14], address-register load [13], read/write [12:11], branch condition [10:8], target [7:0]. The word at microstore address 0 is 0x304D2000, which decodes to C=6, A=1, B=6, ALU=4 and address-register load=1.
- R7: The branch condition codes are: 0 = never, 1 = always, 2 = ALU zero, 3 = ALU negative, 4 = not zero, 5 = not negative, 6 and 7 = never. For the never codes the flag inputs have no effect on the next counter value.
- R8: `c_sel_o`, `a_sel_o` and `b_sel_o` are one-hot, each with only bit k set, where k is the C, A or B field of the held word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one edge per subcycle |
| rst | input | 1 | Synchronous active-high reset |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| alu_neg_i | input | 1 | ALU result-is-negative flag |
| phase_o | output | 3 | One-hot subcycle (bit0 T1, bit1 T2, bit2 T3) |
| upc_o | output | 8 | Microprogram counter |
| uword_o | output | 32 | Held microinstruction |
| c_sel_o | output | 32 | One-hot register write enable |
| a_sel_o | output | 32 | One-hot A-bus output enable |
| b_sel_o | output | 32 | One-hot B-bus output enable |
| alu_fn_o | output | 3 | ALU function field |
| mar_ld_o | output | 1 | Address-register load field |
| mem_rw_o | output | 2 | Memory read/write field |
| br_cond_o | output | 3 | Branch condition field |
| br_addr_o | output | 8 | Branch target field |
| br_take_o | output | 1 | Branch multiplexer output |

## Verification
The bench walks the microprogram through every condition code with each flag value, once where the branch is taken and once where it is not. A sequencer that decodes a condition wrongly, or lets the flags steer a never code, ends up at the wrong next address. One path runs through 0xFE and 0xFF so that the counter must wrap to 0x00; a counter that saturated or overflowed into extra bits would not return to the start of the program. The bench also samples the counter just after T2 to catch a branch applied before the increment. It raises reset in the middle of a microcycle to catch a phase ring that does not return to T1. Finally, it checks the 0x304D2000 word field by field, so a layout with any boundary shifted is exposed.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int ADDR_W = 8;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 5;
  localparam int ALU_W  = 3;
  localparam int RW_W   = 2;
  localparam int COND_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SEL_N  = 1 << SEL_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] uaddr_t;

  typedef struct packed {
    logic [SEL_W-1:0]  c_fld;
    logic [SEL_W-1:0]  a_fld;
    logic [SEL_W-1:0]  b_fld;
    logic [ALU_W-1:0]  alu_fld;
    logic              mar_fld;
    logic [RW_W-1:0]   rw_fld;
    logic [COND_W-1:0] cond_fld;
    uaddr_t            tgt_fld;
  } uinstr_t;

  typedef enum logic [COND_W-1:0] {
    CND_NEVER  = 3'd0,
    CND_ALWAYS = 3'd1,
    CND_ZERO   = 3'd2,
    CND_NEG    = 3'd3,
    CND_NZERO  = 3'd4,
    CND_NNEG   = 3'd5
  } cond_e;

  typedef enum logic [2:0] {
    PH_T1 = 3'b001,
    PH_T2 = 3'b010,
    PH_T3 = 3'b100
  } phase_e;

  function automatic word_t pack_word(input logic [COND_W-1:0] cnd, input uaddr_t tgt);
    uinstr_t w;
    w = '0;
    w.cond_fld = cnd;
    w.tgt_fld  = tgt;
    return word_t'(w);
  endfunction

  // Constant microprogram: a few branch words, everything else filler
  // whose fields are derived from the address and never branch.
  function automatic word_t ucode_word(input uaddr_t a);
    uinstr_t w;
    w.c_fld    = a[4:0];
    w.a_fld    = a[7:3];
    w.b_fld    = ~a[4:0];
    w.alu_fld  = a[2:0];
    w.mar_fld  = a[0];
    w.rw_fld   = a[2:1];
    w.cond_fld = CND_NEVER;
    w.tgt_fld  = a + 8'h55;
    case (a)
      8'h00: return 32'h304D_2000;
      8'h03: return pack_word(CND_ALWAYS, 8'h10);
      8'h12: return pack_word(CND_ZERO,   8'h20);
      8'h13: return pack_word(CND_ALWAYS, 8'h20);
      8'h20: return pack_word(CND_NEG,    8'h30);
      8'h21: return pack_word(CND_ALWAYS, 8'h30);
      8'h30: return pack_word(CND_NZERO,  8'h40);
      8'h31: return pack_word(CND_ALWAYS, 8'h40);
      8'h40: return pack_word(CND_NNEG,   8'h50);
      8'h41: return pack_word(CND_ALWAYS, 8'h50);
      8'h50: return pack_word(3'd6,       8'h60);
      8'h51: return pack_word(CND_ALWAYS, 8'h60);
      8'h60: return pack_word(CND_ZERO,   8'hFE);
      8'h61: return pack_word(CND_ALWAYS, 8'h12);
      default: return word_t'(w);
    endcase
  endfunction

endpackage

// File: rtl/useq_phase.sv
module useq_phase
  import useq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_T1;
    end else begin
      case (phase)
        PH_T1:   phase <= PH_T2;
        PH_T2:   phase <= PH_T3;
        default: phase <= PH_T1;
      endcase
    end
  end

  p_phase_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(phase) == 1);
  p_phase_t1_r2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_T1 |=> phase == PH_T2);
  p_phase_t2_r2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_T2 |=> phase == PH_T3);
  p_phase_t3_r2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_T3 |=> phase == PH_T1);

endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  uaddr_t addr,
  output word_t  rdata
);

  // Read-only microstore: the content is a constant function of the
  // address, so synthesis folds it into a ROM.
  always_comb rdata = ucode_word(addr);

endmodule

// File: rtl/useq_branch_mux.sv
module useq_branch_mux
  import useq_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic              alu_zero,
  input  logic              alu_neg,
  output logic              take
);

  always_comb begin
    case (cond)
      CND_ALWAYS: take = 1'b1;
      CND_ZERO:   take = alu_zero;
      CND_NEG:    take = alu_neg;
      CND_NZERO:  take = ~alu_zero;
      CND_NNEG:   take = ~alu_neg;
      default:    take = 1'b0;
    endcase
  end

endmodule

// File: rtl/useq_decode.sv
module useq_decode #(
  parameter int IN_W = 5
) (
  input  logic [IN_W-1:0]       code,
  output logic [(1<<IN_W)-1:0]  sel
);

  localparam int OUT_W = 1 << IN_W;

  always_comb begin
    sel = '0;
    for (int k = 0; k < OUT_W; k++) begin
      if (code == IN_W'(k)) sel[k] = 1'b1;
    end
  end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        alu_zero_i,
  input  logic        alu_neg_i,
  output logic [2:0]  phase_o,
  output logic [7:0]  upc_o,
  output logic [31:0] uword_o,
  output logic [31:0] c_sel_o,
  output logic [31:0] a_sel_o,
  output logic [31:0] b_sel_o,
  output logic [2:0]  alu_fn_o,
  output logic        mar_ld_o,
  output logic [1:0]  mem_rw_o,
  output logic [2:0]  br_cond_o,
  output logic [7:0]  br_addr_o,
  output logic        br_take_o
);

  localparam int NFLD = 3;

  phase_e  phase_q;
  uaddr_t  upc_q;
  word_t   uword_q;
  word_t   rom_q;
  uinstr_t ui;
  logic    take;

  logic [SEL_W-1:0] fld_code [NFLD];
  logic [SEL_N-1:0] fld_sel  [NFLD];

  useq_phase i_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (phase_q)
  );

  useq_store i_store (
    .addr  (upc_q),
    .rdata (rom_q)
  );

  assign ui = uinstr_t'(uword_q);

  useq_branch_mux i_bmux (
    .cond     (ui.cond_fld),
    .alu_zero (alu_zero_i),
    .alu_neg  (alu_neg_i),
    .take     (take)
  );

  assign fld_code[0] = ui.c_fld;
  assign fld_code[1] = ui.a_fld;
  assign fld_code[2] = ui.b_fld;

  for (genvar g = 0; g < NFLD; g++) begin : g_dec
    useq_decode #(.IN_W(SEL_W)) i_dec (
      .code (fld_code[g]),
      .sel  (fld_sel[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upc_q   <= '0;
      uword_q <= '0;
    end else begin
      case (phase_q)
        PH_T1: uword_q <= rom_q;
        PH_T2: upc_q   <= upc_q + 1'b1;
        PH_T3: if (take) upc_q <= ui.tgt_fld;
        default: ;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign upc_o     = upc_q;
  assign uword_o   = uword_q;
  assign c_sel_o   = fld_sel[0];
  assign a_sel_o   = fld_sel[1];
  assign b_sel_o   = fld_sel[2];
  assign alu_fn_o  = ui.alu_fld;
  assign mar_ld_o  = ui.mar_fld;
  assign mem_rw_o  = ui.rw_fld;
  assign br_cond_o = ui.cond_fld;
  assign br_addr_o = ui.tgt_fld;
  assign br_take_o = take;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (upc_q == '0 && uword_q == '0 && phase_q == PH_T1));
  p_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_T1 |=> uword_q == $past(rom_q));
  p_mir_hold_r3: assert property (@(posedge clk) disable iff (rst)
    phase_q != PH_T1 |=> $stable(uword_q));
  p_upc_inc_r4: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_T2 |=> upc_q == uaddr_t'($past(upc_q) + 1'b1));
  p_upc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_T3 && !br_take_o) |=> $stable(upc_q));
  p_upc_branch_r5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_T3 && br_take_o) |=> upc_q == $past(br_addr_o));
  p_upc_t1_r5: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_T1 |=> $stable(upc_q));
  p_never_r7: assert property (@(posedge clk) disable iff (rst)
    (br_cond_o == 3'd0 || br_cond_o == 3'd6 || br_cond_o == 3'd7) |-> !br_take_o);
  p_csel_r8: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_T1 |=> c_sel_o == (32'd1 << $past(rom_q[31:27])));
  p_asel_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(a_sel_o) == 1 && $countones(b_sel_o) == 1);

endmodule

// File: tb/test_useq_sequencer.sv
module test_useq_sequencer;
  import useq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 28;

  // {alu_zero, alu_neg, address expected in the counter at T1}
  localparam logic [9:0] VEC [NVEC] = '{
    10'h000, 10'h001, 10'h002, 10'h003, 10'h010, 10'h011, 10'h212,
    10'h120, 10'h230, 10'h031, 10'h040, 10'h350, 10'h051, 10'h060,
    10'h061, 10'h112, 10'h013, 10'h020, 10'h021, 10'h130, 10'h140,
    10'h041, 10'h050, 10'h051, 10'h260, 10'h0FE, 10'h0FF, 10'h000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alu_zero_i = 1'b0;
  logic alu_neg_i = 1'b0;
  logic [2:0]  phase_o;
  logic [7:0]  upc_o;
  logic [31:0] uword_o, c_sel_o, a_sel_o, b_sel_o;
  logic [2:0]  alu_fn_o, br_cond_o;
  logic        mar_ld_o, br_take_o;
  logic [1:0]  mem_rw_o;
  logic [7:0]  br_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_sequencer i_useq_sequencer (
    .clk(clk), .rst(rst), .alu_zero_i(alu_zero_i), .alu_neg_i(alu_neg_i),
    .phase_o(phase_o), .upc_o(upc_o), .uword_o(uword_o),
    .c_sel_o(c_sel_o), .a_sel_o(a_sel_o), .b_sel_o(b_sel_o),
    .alu_fn_o(alu_fn_o), .mar_ld_o(mar_ld_o), .mem_rw_o(mem_rw_o),
    .br_cond_o(br_cond_o), .br_addr_o(br_addr_o), .br_take_o(br_take_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_take(input logic [2:0] cd, input logic z, input logic n);
    case (cd)
      3'd1: return 1'b1;
      3'd2: return z;
      3'd3: return n;
      3'd4: return !z;
      3'd5: return !n;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 upc", 32'(upc_o), 32'h0);
    check("R1 uword", uword_o, 32'h0);
    check("R2 phase at reset", 32'(phase_o), 32'h1);
    check("R8 c_sel of zero word", c_sel_o, 32'h1);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] a;
      logic z, n;
      a = VEC[i][7:0];
      z = VEC[i][9];
      n = VEC[i][8];
      check("R5 counter at T1", 32'(upc_o), 32'(a));
      check("R2 phase T1", 32'(phase_o), 32'h1);
      alu_zero_i = z;
      alu_neg_i  = n;
      step();
      w = ucode_word(a);
      check("R3 fetched word", uword_o, w);
      check("R2 phase T2", 32'(phase_o), 32'h2);
      check("R8 c_sel", c_sel_o, 32'd1 << w[31:27]);
      check("R8 a_sel", a_sel_o, 32'd1 << w[26:22]);
      check("R8 b_sel", b_sel_o, 32'd1 << w[21:17]);
      check("R6 fields", {16'h0, alu_fn_o, mar_ld_o, mem_rw_o, br_cond_o, br_addr_o},
            {16'h0, w[16:14], w[13], w[12:11], w[10:8], w[7:0]});
      check("R7 branch mux", 32'(br_take_o), 32'(exp_take(w[10:8], z, n)));
      step();
      check("R4 increment at T2", 32'(upc_o), 32'(8'(a + 8'd1)));
      check("R3 word held at T2", uword_o, w);
      check("R2 phase T3", 32'(phase_o), 32'h4);
      step();
    end

    // R1 reset raised in the middle of a microcycle (after T2 edge)
    alu_zero_i = 1'b0;
    alu_neg_i  = 1'b0;
    step();
    step();
    rst = 1'b1;
    step();
    check("R1 mid-cycle upc", 32'(upc_o), 32'h0);
    check("R1 mid-cycle uword", uword_o, 32'h0);
    check("R1 mid-cycle phase", 32'(phase_o), 32'h1);
    rst = 1'b0;
    step();
    // R6 reference word at address 0
    check("R6 word 0", uword_o, 32'h304D2000);
    check("R6 C=6", c_sel_o, 32'd1 << 6);
    check("R6 A=1", a_sel_o, 32'd1 << 1);
    check("R6 B=6", b_sel_o, 32'd1 << 6);
    check("R6 ALU=4", 32'(alu_fn_o), 32'd4);
    check("R6 addr-reg load", 32'(mar_ld_o), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule